// File: doc/BRIEF.md
# Power-On Strap Capture and Clock Mode Decoder

This block sits in a clock generator next to a pad that serves two purposes. Right after power-up the pad is an input, and it carries a board-level strap that picks the host frequency. A window timer runs on the free-running reference clock. While it runs, the block keeps sampling the strap pad, the frequency select input and the active-low tristate input. When the timer expires, the last sampled values are frozen and the pad output enable is raised. The pad cell then drives the reference clock onto the same pin.

The frozen strap, select and tristate levels are decoded into a mode code for the downstream divider logic. The possible modes are:
- outputs off,
- all outputs high-impedance,
- a test mode in which every clock group divides an overdriven test clock by a fixed ratio,
- one of four normal host/memory frequency pairings.

The active-low power-down input is asynchronous and is synchronized inside the block. While it is low during power-up, the window timer is frozen. Once the window has closed, holding power-down low forces the clocks off without disturbing the frozen selection. Only a new power-up reset re-opens the window.

Top module: `strap_mode_ctrl`

## Requirements
- R1: While `rst_por_n` is low, `strap_pin_oe` is 0 and `mode_code` is 0 (off). `cpu_sel` is 3 (no host clock), `sdram_133` is 0, and all six test divisors are 0.
- R2: With `pwr_dn_n` held high, `strap_pin_oe` rises exactly `SYNC_STAGES + STRAP_CYCLES` rising edges of `clk_ref` after `rst_por_n` is released. It then stays high until the next reset.
- R3: While the synchronized `pwr_dn_n` is low before the window has closed, the window timer holds its count and `strap_pin_oe` stays low. An L-cycle low pulse delays the rise of `strap_pin_oe` by exactly L cycles.
- R4: `strap_pin_in`, `sel0_in` and `tristate_n_in` are captured at the edge on which the window closes. Changes to them after that edge have no effect on any decoded output.
- R5: With captured tristate = 0 and select = 0, `mode_code` is 1 (high-impedance) and `outputs_hiz` is 1, whatever the strap level.
- R6: With captured tristate = 0 and select = 1, `mode_code` is 2 (test). The test divisors are then 4 for host, 4 for memory, 6 for the 66 MHz group, 12 for the 33 MHz group, 2 for the 48 MHz group and 1 for the reference. In every other mode each test divisor is 0.
- R7: With captured tristate = 1, the code {strap, select} selects the normal mode:
  - 00 gives `mode_code` 3 (host 66 / memory 100), `cpu_sel` 0.
  - 01 gives `mode_code` 4 (100/100), `cpu_sel` 1.
  - 10 gives `mode_code` 5 (133/133), `cpu_sel` 2, `sdram_133` 1.
  - 11 gives `mode_code` 6 (133/100), `cpu_sel` 2.
  In the off, high-impedance and test modes `cpu_sel` is 3.
- R8: While `strap_pin_oe` is low, `mode_code` is 0 and `clocks_low` is 1.
- R9: After the window has closed, `pwr_dn_n` low for `SYNC_STAGES` sampling edges forces `mode_code` to 0 and `clocks_low` to 1, while `strap_pin_oe` stays high. The same delay applies after `pwr_dn_n` returns high, after which the frozen mode comes back.
- R10: A new power-up reset re-opens the window, so the inputs are captured again and may produce a different mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst_por_n | input | 1 | Power-up reset, active low, asynchronous |
| pwr_dn_n | input | 1 | Power-down request, active low, asynchronous |
| strap_pin_in | input | 1 | Level seen on the shared strap/reference pad |
| sel0_in | input | 1 | Frequency select input |
| tristate_n_in | input | 1 | Output tristate request, active low |
| strap_pin_oe | output | 1 | Pad output enable; 1 once the strap window has closed |
| mode_code | output | 3 | 0 off, 1 high-Z, 2 test, 3..6 normal pairings |
| cpu_sel | output | 2 | Host clock: 0=66, 1=100, 2=133, 3=none |
| sdram_133 | output | 1 | Memory clocks run at 133 MHz |
| outputs_hiz | output | 1 | All clock outputs high-impedance |
| clocks_low | output | 1 | All clock outputs held low |
| tdiv_cpu | output | DIV_W | Test-clock divisor, host group |
| tdiv_sdram | output | DIV_W | Test-clock divisor, memory group |
| tdiv_v66 | output | DIV_W | Test-clock divisor, 66 MHz group |
| tdiv_pci | output | DIV_W | Test-clock divisor, 33 MHz and interrupt-controller group |
| tdiv_usb | output | DIV_W | Test-clock divisor, 48 MHz group |
| tdiv_ref | output | DIV_W | Test-clock divisor, reference output |

## Verification
The checker assumes a synchronizer depth of two when it relates a held-low power-down input to the clocks being forced off. The bench therefore keeps `SYNC_STAGES` at its default. The properties also assume that the strap and select inputs change only at clock-relative points, not asynchronously inside the capture edge. The stimulus respects this: every input is driven at the falling edge of `clk_ref`, and the strap, select and tristate levels are held steady until `strap_pin_oe` is seen high. The power-down input is stepped for whole cycles, so each pause and each forced-off interval has an exact cycle length that the bench predicts.

// File: rtl/strap_mode_pkg.sv
package strap_mode_pkg;

    typedef enum logic [2:0] {
        MODE_OFF       = 3'd0,
        MODE_HIZ       = 3'd1,
        MODE_TEST      = 3'd2,
        MODE_C66_S100  = 3'd3,
        MODE_C100_S100 = 3'd4,
        MODE_C133_S133 = 3'd5,
        MODE_C133_S100 = 3'd6
    } mode_e;

    typedef enum logic [1:0] {
        CPU_66   = 2'd0,
        CPU_100  = 2'd1,
        CPU_133  = 2'd2,
        CPU_NONE = 2'd3
    } cpu_sel_e;

    // Test-clock divide ratios per output group
    localparam int TDIV_CPU   = 4;
    localparam int TDIV_SDRAM = 4;
    localparam int TDIV_V66   = 6;
    localparam int TDIV_PCI   = 12;
    localparam int TDIV_USB   = 2;
    localparam int TDIV_REF   = 1;

    // Captured select levels
    typedef struct packed {
        logic strap;
        logic sel0;
        logic tri_n;
    } sel_cap_t;

endpackage

// File: rtl/strap_pd_sync.sv
module strap_pd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.sh[0] = din;
            end
        end else begin : g_chain
            always_comb begin
                st_d = st_q;
                st_d.sh = {st_q.sh[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.sh[STAGES-1];
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int STRAP_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (STRAP_CYCLES < 2) ? 1 : $clog2(STRAP_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(STRAP_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run && !st_q.done) begin
            if (st_q.cnt == LAST) st_d.done = 1'b1;
            else                  st_d.cnt  = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
endmodule

// File: rtl/strap_latch.sv
module strap_latch
    import strap_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frozen,
    input  logic     strap_lvl,
    input  logic     sel0_lvl,
    input  logic     tri_n_lvl,
    output sel_cap_t cap
);
    typedef struct packed {
        sel_cap_t cap;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!frozen) begin
            st_d.cap.strap = strap_lvl;
            st_d.cap.sel0  = sel0_lvl;
            st_d.cap.tri_n = tri_n_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap = st_q.cap;
endmodule

// File: rtl/strap_mode_decode.sv
module strap_mode_decode
    import strap_mode_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  logic             run,
    input  sel_cap_t         cap,
    output mode_e            mode,
    output cpu_sel_e         cpu_sel,
    output logic             sdram_133,
    output logic [DIV_W-1:0] tdiv_cpu,
    output logic [DIV_W-1:0] tdiv_sdram,
    output logic [DIV_W-1:0] tdiv_v66,
    output logic [DIV_W-1:0] tdiv_pci,
    output logic [DIV_W-1:0] tdiv_usb,
    output logic [DIV_W-1:0] tdiv_ref
);
    logic is_test;

    always_comb begin
        mode = MODE_OFF;
        if (run) begin
            if (!cap.tri_n) begin
                mode = cap.sel0 ? MODE_TEST : MODE_HIZ;
            end else begin
                case ({cap.strap, cap.sel0})
                    2'b00:   mode = MODE_C66_S100;
                    2'b01:   mode = MODE_C100_S100;
                    2'b10:   mode = MODE_C133_S133;
                    default: mode = MODE_C133_S100;
                endcase
            end
        end
    end

    always_comb begin
        case (mode)
            MODE_C66_S100:  cpu_sel = CPU_66;
            MODE_C100_S100: cpu_sel = CPU_100;
            MODE_C133_S133,
            MODE_C133_S100: cpu_sel = CPU_133;
            default:        cpu_sel = CPU_NONE;
        endcase
        sdram_133 = (mode == MODE_C133_S133);
        is_test   = (mode == MODE_TEST);
        tdiv_cpu   = is_test ? DIV_W'(TDIV_CPU)   : '0;
        tdiv_sdram = is_test ? DIV_W'(TDIV_SDRAM) : '0;
        tdiv_v66   = is_test ? DIV_W'(TDIV_V66)   : '0;
        tdiv_pci   = is_test ? DIV_W'(TDIV_PCI)   : '0;
        tdiv_usb   = is_test ? DIV_W'(TDIV_USB)   : '0;
        tdiv_ref   = is_test ? DIV_W'(TDIV_REF)   : '0;
    end
endmodule

// File: rtl/strap_mode_ctrl.sv
module strap_mode_ctrl
    import strap_mode_pkg::*;
#(
    parameter int STRAP_CYCLES = 28636,
    parameter int SYNC_STAGES  = 2,
    parameter int DIV_W        = 4
) (
    input  logic             clk_ref,
    input  logic             rst_por_n,
    input  logic             pwr_dn_n,
    input  logic             strap_pin_in,
    input  logic             sel0_in,
    input  logic             tristate_n_in,
    output logic             strap_pin_oe,
    output logic [2:0]       mode_code,
    output logic [1:0]       cpu_sel,
    output logic             sdram_133,
    output logic             outputs_hiz,
    output logic             clocks_low,
    output logic [DIV_W-1:0] tdiv_cpu,
    output logic [DIV_W-1:0] tdiv_sdram,
    output logic [DIV_W-1:0] tdiv_v66,
    output logic [DIV_W-1:0] tdiv_pci,
    output logic [DIV_W-1:0] tdiv_usb,
    output logic [DIV_W-1:0] tdiv_ref
);
    logic     pd_ok;
    logic     window_done;
    sel_cap_t cap;
    mode_e    mode;
    cpu_sel_e cpu_sel_w;

    strap_pd_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
        .clk   (clk_ref),
        .rst_n (rst_por_n),
        .din   (pwr_dn_n),
        .dout  (pd_ok)
    );

    strap_window_timer #(.STRAP_CYCLES(STRAP_CYCLES)) u_timer (
        .clk   (clk_ref),
        .rst_n (rst_por_n),
        .run   (pd_ok),
        .done  (window_done)
    );

    strap_latch u_latch (
        .clk       (clk_ref),
        .rst_n     (rst_por_n),
        .frozen    (window_done),
        .strap_lvl (strap_pin_in),
        .sel0_lvl  (sel0_in),
        .tri_n_lvl (tristate_n_in),
        .cap       (cap)
    );

    strap_mode_decode #(.DIV_W(DIV_W)) u_decode (
        .run        (window_done && pd_ok),
        .cap        (cap),
        .mode       (mode),
        .cpu_sel    (cpu_sel_w),
        .sdram_133  (sdram_133),
        .tdiv_cpu   (tdiv_cpu),
        .tdiv_sdram (tdiv_sdram),
        .tdiv_v66   (tdiv_v66),
        .tdiv_pci   (tdiv_pci),
        .tdiv_usb   (tdiv_usb),
        .tdiv_ref   (tdiv_ref)
    );

    assign strap_pin_oe = window_done;
    assign mode_code    = mode;
    assign cpu_sel      = cpu_sel_w;
    assign outputs_hiz  = (mode == MODE_HIZ);
    assign clocks_low   = (mode == MODE_OFF);
endmodule

// File: rtl/strap_mode_ctrl_chk.sv
module strap_mode_ctrl_chk #(
    parameter int DIV_W = 4
) (
    input logic             clk_ref,
    input logic             rst_por_n,
    input logic             pwr_dn_n,
    input logic             strap_pin_oe,
    input logic [2:0]       mode_code,
    input logic [1:0]       cpu_sel,
    input logic [DIV_W-1:0] tdiv_cpu,
    input logic [DIV_W-1:0] tdiv_pci
);
    // R2
    oe_sticky_chk: assert property (@(posedge clk_ref) disable iff (!rst_por_n)
        strap_pin_oe |=> strap_pin_oe);

    // R8
    off_before_window_chk: assert property (@(posedge clk_ref) disable iff (!rst_por_n)
        !strap_pin_oe |-> (mode_code == 3'd0));

    // R4
    frozen_mode_chk: assert property (@(posedge clk_ref) disable iff (!rst_por_n)
        (strap_pin_oe && $past(strap_pin_oe) && mode_code != 3'd0 && $past(mode_code) != 3'd0)
        |-> $stable(mode_code));

    // R6
    test_divs_chk: assert property (@(posedge clk_ref) disable iff (!rst_por_n)
        (mode_code == 3'd2) |-> (tdiv_cpu == DIV_W'(4) && tdiv_pci == DIV_W'(12)));

    // R6
    no_div_outside_test_chk: assert property (@(posedge clk_ref) disable iff (!rst_por_n)
        (mode_code != 3'd2) |-> (tdiv_cpu == '0 && tdiv_pci == '0));

    // R7
    host_none_chk: assert property (@(posedge clk_ref) disable iff (!rst_por_n)
        (mode_code < 3'd3) |-> (cpu_sel == 2'd3));

    // R9 (two-stage synchronizer)
    pd_forces_off_chk: assert property (@(posedge clk_ref) disable iff (!rst_por_n)
        (!pwr_dn_n && $past(!pwr_dn_n)) |=> (mode_code == 3'd0));
endmodule

bind strap_mode_ctrl strap_mode_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_ref      (clk_ref),
    .rst_por_n    (rst_por_n),
    .pwr_dn_n     (pwr_dn_n),
    .strap_pin_oe (strap_pin_oe),
    .mode_code    (mode_code),
    .cpu_sel      (cpu_sel),
    .tdiv_cpu     (tdiv_cpu),
    .tdiv_pci     (tdiv_pci)
);

// File: tb/strap_mode_ctrl_bench.sv
module strap_mode_ctrl_bench;
    localparam int N     = 16;
    localparam int SYNC  = 2;
    localparam int DW    = 4;
    localparam int HALF  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b1;
    logic strap = 1'b0;
    logic sel0 = 1'b0;
    logic tri_n = 1'b1;
    logic oe;
    logic [2:0] mode;
    logic [1:0] cpu_sel;
    logic sd133, hiz, clow;
    logic [DW-1:0] d_cpu, d_sd, d_v66, d_pci, d_usb, d_ref;

    int checks = 0;
    int failures = 0;

    always #HALF clk = ~clk;

    strap_mode_ctrl #(.STRAP_CYCLES(N), .SYNC_STAGES(SYNC), .DIV_W(DW)) u_strap_mode_ctrl (
        .clk_ref(clk), .rst_por_n(rst_n), .pwr_dn_n(pd_n),
        .strap_pin_in(strap), .sel0_in(sel0), .tristate_n_in(tri_n),
        .strap_pin_oe(oe), .mode_code(mode), .cpu_sel(cpu_sel),
        .sdram_133(sd133), .outputs_hiz(hiz), .clocks_low(clow),
        .tdiv_cpu(d_cpu), .tdiv_sdram(d_sd), .tdiv_v66(d_v66),
        .tdiv_pci(d_pci), .tdiv_usb(d_usb), .tdiv_ref(d_ref)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Reset with given input levels; checks reset state (R1)
    task automatic do_reset(input bit t, input bit s0, input bit st, input bit pd);
        @(negedge clk);
        rst_n = 1'b0; tri_n = t; sel0 = s0; strap = st; pd_n = pd;
        repeat (3) @(negedge clk);
        chk(oe == 1'b0, "R1 oe", oe, 0);
        chk(mode == 3'd0 && clow, "R1 mode", mode, 0);
        chk(cpu_sel == 2'd3 && !sd133, "R1 cpu_sel", cpu_sel, 3);
        chk((d_cpu | d_sd | d_v66 | d_pci | d_usb | d_ref) == '0, "R1 divisors", d_pci, 0);
        rst_n = 1'b1;
    endtask

    // Counts rising edges until oe is seen high; checks R8 on the way
    task automatic wait_oe(output int edges);
        bit early = 1'b0;
        edges = 0;
        while (!oe && edges < 1000) begin
            if (mode != 3'd0 || !clow) early = 1'b1;
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        chk(!early, "R8 off before window", early, 0);
    endtask

    function automatic int exp_mode(input bit t, input bit s0, input bit st);
        return t ? (3 + 2 * st + s0) : (1 + s0);
    endfunction

    function automatic int exp_cpu(input bit t, input bit s0, input bit st);
        return !t ? 3 : (st ? 2 : (s0 ? 1 : 0));
    endfunction

    initial begin
        #(HALF * 2 * 150000);
        failures++;
        checks++;
        $display("FAIL R2 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        int e;
        int m;
        // Sweep all captured select combinations (R5, R6, R7, R10)
        for (int i = 0; i < 8; i++) begin
            bit t  = i[2];
            bit s0 = i[1];
            bit st = i[0];
            do_reset(t, s0, st, 1'b1);
            wait_oe(e);
            chk(e == SYNC + N, "R2 window length", e, SYNC + N);
            m = exp_mode(t, s0, st);
            chk(mode == 3'(m), "R10 recaptured mode", mode, m);
            if (!t && !s0)
                chk(mode == 3'd1 && hiz && !clow, "R5 high-Z", mode, 1);
            else if (!t)
                chk(mode == 3'd2, "R6 test mode", mode, 2);
            else
                chk(mode == 3'(m), "R7 normal mode", mode, m);
            chk(cpu_sel == 2'(exp_cpu(t, s0, st)), "R7 cpu_sel", cpu_sel, exp_cpu(t, s0, st));
            chk(sd133 == (t && st && !s0), "R7 sdram_133", sd133, int'(t && st && !s0));
            if (!t && s0) begin
                chk(d_cpu == 4 && d_sd == 4, "R6 host/mem div", d_cpu, 4);
                chk(d_v66 == 6 && d_pci == 12, "R6 66/33 div", d_pci, 12);
                chk(d_usb == 2 && d_ref == 1, "R6 48/ref div", d_usb, 2);
            end else begin
                chk((d_cpu | d_sd | d_v66 | d_pci | d_usb | d_ref) == '0, "R6 div zero", d_pci, 0);
            end
            // Inputs flipped after the window: no effect (R4)
            tri_n = ~t; sel0 = ~s0; strap = ~st;
            repeat (4) @(negedge clk);
            chk(mode == 3'(m), "R4 frozen mode", mode, m);
            chk(cpu_sel == 2'(exp_cpu(t, s0, st)), "R4 frozen cpu_sel", cpu_sel, exp_cpu(t, s0, st));
            chk(oe == 1'b1, "R2 oe stays high", oe, 1);
        end

        // Power-down held low at power-up freezes the timer (R3)
        do_reset(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (30) @(negedge clk);
        chk(oe == 1'b0, "R3 oe held low", oe, 0);
        pd_n = 1'b1;
        wait_oe(e);
        chk(e == SYNC + N, "R3 start after release", e, SYNC + N);

        // Power-down pulse mid-window delays by its length (R3)
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        repeat (5) @(negedge clk);
        pd_n = 1'b0;
        repeat (7) @(negedge clk);
        pd_n = 1'b1;
        wait_oe(e);
        chk(e + 12 == SYNC + N + 7, "R3 paused window", e + 12, SYNC + N + 7);
        chk(mode == 3'd5, "R7 133/133 after pause", mode, 5);

        // Power-down after the window (R9)
        pd_n = 1'b0;
        @(negedge clk);
        chk(mode == 3'd5, "R9 one edge not yet off", mode, 5);
        @(negedge clk);
        chk(mode == 3'd0 && clow, "R9 clocks forced low", mode, 0);
        chk(oe == 1'b1, "R9 oe kept", oe, 1);
        repeat (5) @(negedge clk);
        pd_n = 1'b1;
        @(negedge clk);
        chk(mode == 3'd0, "R9 still off one edge", mode, 0);
        @(negedge clk);
        chk(mode == 3'd5 && !clow, "R9 frozen mode back", mode, 5);

        summary();
        $finish;
    end
endmodule